// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two interrupt outputs for a processor, one normal and one critical. Each request line passes through a two-flop synchroniser. It is then sensed either as a level or as an edge, and per-source configuration bits choose which and set the active polarity. Detected events are held in a status word until software clears them by writing ones. An enable word gates the status into a masked status, and a per-source routing bit sends each enabled pending source to the normal or the critical output.

Software reaches the block through a small word-addressed register port, where read data appears one clock after the address. A computed vector register gives the number of the lowest-numbered enabled pending source. A separate vector configuration word is kept as plain read/write storage. The normal output of one instance may drive a request line of another instance, so controllers can be chained.

Top module: `evt_irq_hub`

## Requirements
- R1: Request line `irq_in[n]` (source n) appears at bit 31−n of every per-source register, so source 0 is the most significant bit.
- R2: After reset the status, enable, routing and trigger words read 0, the polarity word reads all ones, the vector reads all ones, and both interrupt outputs are low.
- R3: Trigger bit 1 selects edge sensing and 0 selects level sensing. Polarity bit 1 selects the rising edge or high level, and 0 selects the falling edge or low level. A change on a request line reaches the status word at the third rising clock edge after the change.
- R4: Writing to the status word (offset 0x0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: An edge event stays pending after the line returns to its idle level, until it is cleared. A level source whose line is still active stays pending through a clear, whether it is enabled or not.
- R6: Offset 0x6 reads status AND enable. Writes to it have no effect.
- R7: `irq_norm` is high when an enabled pending source has routing bit 0. `irq_crit` is high when an enabled pending source has routing bit 1. Routing is at offset 0x3.
- R8: When a hardware event and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R9: The register offsets are status 0x0, enable 0x2, routing 0x3, polarity 0x4, trigger 0x5, masked 0x6, vector 0x7 and vector configuration 0x8. Read data is registered and valid on the cycle after the address. Offset 0x8 is read/write storage. Every other offset reads zero and ignores writes.
- R10: Offset 0x7 reads the number of the lowest-numbered enabled pending source, or all ones when there is none. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw request lines, bit n is source n |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the address |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
Random trials choose fresh polarity, trigger, enable and routing words. Each trial drives a random pattern of sources to their active level, then back to idle, then active again, with clears in between. Idle-then-active separates edge sources from level sources, return-to-idle shows that events are latched, and a clear with lines held active separates level re-setting from edge clearing. Directed cases cover the exact synchroniser latency, a clear that meets an edge event in the same cycle, and one cycle later. They also cover writes to read-only and unused offsets, and the reset values.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_ROUTE  = 4'h3;
  localparam logic [ADDR_W-1:0] OFF_POLAR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_TRIG   = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_VECTOR = 4'h7;
  localparam logic [ADDR_W-1:0] OFF_VCFG   = 4'h8;

  // register bit that holds source n
  function automatic int src_bit(input int n, input int nsrc);
    return nsrc - 1 - n;
  endfunction
endpackage

// File: rtl/irq_hub_front.sv
module irq_hub_front #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] polar,
  input  logic [NSRC-1:0] trig,
  output logic [NSRC-1:0] set_vec
);
  import irq_hub_pkg::*;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int POS = src_bit(n, NSRC);
    logic s1_q, s2_q, prev_q;
    logic active, edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= irq_in[n];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    always_comb begin
      active   = polar[POS] ? s2_q : ~s2_q;
      edge_hit = polar[POS] ? (s2_q & ~prev_q) : (~s2_q & prev_q);
      set_vec[POS] = trig[POS] ? edge_hit : active;
    end
  end
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs #(
  parameter int NSRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [irq_hub_pkg::ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]               reg_wdata,
  input  logic [NSRC-1:0]               set_vec,
  output logic [NSRC-1:0]               status_q,
  output logic [NSRC-1:0]               enable_q,
  output logic [NSRC-1:0]               route_q,
  output logic [NSRC-1:0]               polar_q,
  output logic [NSRC-1:0]               trig_q,
  output logic [NSRC-1:0]               vcfg_q
);
  import irq_hub_pkg::*;

  logic [NSRC-1:0] clr_vec;

  always_comb begin
    clr_vec = (reg_wr && reg_addr == OFF_STATUS) ? reg_wdata : '0;
  end

  // a hardware event outranks a software clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      route_q  <= '0;
      polar_q  <= '1;
      trig_q   <= '0;
      vcfg_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_ENABLE: enable_q <= reg_wdata;
        OFF_ROUTE:  route_q  <= reg_wdata;
        OFF_POLAR:  polar_q  <= reg_wdata;
        OFF_TRIG:   trig_q   <= reg_wdata;
        OFF_VCFG:   vcfg_q   <= reg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] masked,
  output logic [NSRC-1:0] vec_val
);
  function automatic logic [NSRC-1:0] lowest_src(input logic [NSRC-1:0] m);
    logic [NSRC-1:0] r;
    r = '1;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (m[NSRC-1-n]) r = NSRC'(n);
    end
    return r;
  endfunction

  always_comb vec_val = lowest_src(masked);
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int NSRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC-1:0]               irq_in,
  input  logic [irq_hub_pkg::ADDR_W-1:0] reg_addr,
  input  logic                          reg_wr,
  input  logic [NSRC-1:0]               reg_wdata,
  output logic [NSRC-1:0]               reg_rdata,
  output logic                          irq_norm,
  output logic                          irq_crit
);
  import irq_hub_pkg::*;

  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] status_q, enable_q, route_q, polar_q, trig_q, vcfg_q;
  logic [NSRC-1:0] masked, vec_val, rd_mux;

  irq_hub_front #(.NSRC(NSRC)) u_front (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .polar(polar_q), .trig(trig_q), .set_vec(set_vec)
  );

  irq_hub_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .set_vec(set_vec),
    .status_q(status_q), .enable_q(enable_q), .route_q(route_q),
    .polar_q(polar_q), .trig_q(trig_q), .vcfg_q(vcfg_q)
  );

  assign masked = status_q & enable_q;

  irq_hub_prio #(.NSRC(NSRC)) u_prio (
    .masked(masked), .vec_val(vec_val)
  );

  assign irq_norm = |(masked & ~route_q);
  assign irq_crit = |(masked & route_q);

  always_comb begin
    case (reg_addr)
      OFF_STATUS: rd_mux = status_q;
      OFF_ENABLE: rd_mux = enable_q;
      OFF_ROUTE:  rd_mux = route_q;
      OFF_POLAR:  rd_mux = polar_q;
      OFF_TRIG:   rd_mux = trig_q;
      OFF_MASKED: rd_mux = masked;
      OFF_VECTOR: rd_mux = vec_val;
      OFF_VCFG:   rd_mux = vcfg_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int NSRC = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [irq_hub_pkg::ADDR_W-1:0] reg_addr,
  input logic                          reg_wr,
  input logic [NSRC-1:0]               reg_wdata,
  input logic [NSRC-1:0]               reg_rdata,
  input logic                          irq_norm,
  input logic                          irq_crit,
  input logic [NSRC-1:0]               status,
  input logic [NSRC-1:0]               enable,
  input logic [NSRC-1:0]               route,
  input logic [NSRC-1:0]               set_vec,
  input logic [NSRC-1:0]               vec_val
);
  import irq_hub_pkg::*;

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(reg_wr && reg_addr == OFF_STATUS) |->
      ((status & $past(reg_wdata) & ~$past(set_vec)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ((status & $past(set_vec)) == $past(set_vec))); // R8

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ((status & ~$past(status) & ~$past(set_vec)) == '0)); // R3

  AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(reg_addr) == OFF_MASKED) |-> (reg_rdata == $past(status & enable))); // R6

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(reg_addr) > OFF_VCFG || $past(reg_addr) == 4'h1) |-> (reg_rdata == '0)); // R9

  AST_VEC_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_norm || irq_crit) == (vec_val != '1))); // R10

  AST_CRIT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> (route != '0 && enable != '0)); // R7
endmodule

bind evt_irq_hub irq_hub_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_norm(irq_norm),
  .irq_crit(irq_crit), .status(status_q), .enable(enable_q),
  .route(route_q), .set_vec(set_vec), .vec_val(vec_val)
);

// File: tb/tb_evt_irq_hub.sv
`timescale 1ns/1ps
module tb_evt_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_norm, irq_crit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  function automatic logic [31:0] rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] want_vec(input logic [31:0] m);
    for (int n = 0; n < 32; n++) if (m[31-n]) return 32'(n);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input logic [31:0] st, input logic [31:0] en,
                             input logic [31:0] rt, input string tag);
    logic [31:0] v;
    rd(4'h0, v); chk({tag, " R4 status"}, v, st);
    rd(4'h6, v); chk({tag, " R6 masked"}, v, st & en);
    rd(4'h7, v); chk({tag, " R10 vector"}, v, want_vec(st & en));
    chk({tag, " R7 normal"}, {31'd0, irq_norm}, {31'd0, |(st & en & ~rt)});
    chk({tag, " R7 critical"}, {31'd0, irq_crit}, {31'd0, |(st & en & rt)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R2 reset values
    chk("R2 irq outputs", {30'd0, irq_norm, irq_crit}, 32'd0);
    rd(4'h0, v); chk("R2 status", v, 32'h0);
    rd(4'h2, v); chk("R2 enable", v, 32'h0);
    rd(4'h3, v); chk("R2 route", v, 32'h0);
    rd(4'h4, v); chk("R2 polarity", v, 32'hFFFF_FFFF);
    rd(4'h5, v); chk("R2 trigger", v, 32'h0);
    rd(4'h7, v); chk("R2 vector", v, 32'hFFFF_FFFF);

    // R1 / R3: source 5 level high, latency of three edges
    wr(4'h2, 32'h0400_0000);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); chk("R3 latency edge1", {31'd0, irq_norm}, 32'd0);
    @(negedge clk); chk("R3 latency edge2", {31'd0, irq_norm}, 32'd0);
    @(negedge clk); chk("R3 latency edge3", {31'd0, irq_norm}, 32'd1);
    rd(4'h0, v); chk("R1 source 5 at bit 26", v, 32'h0400_0000);
    rd(4'h7, v); chk("R10 vector source 5", v, 32'd5);

    // R5 level source still active, disabled, survives a clear
    wr(4'h2, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R5 level resets while active", v, 32'h0400_0000);
    irq_in[5] = 1'b0; idle(4);
    wr(4'h0, 32'h0000_0001);
    rd(4'h0, v); chk("R4 zero bits keep status", v, 32'h0400_0000);
    wr(4'h0, 32'h0400_0000);
    rd(4'h0, v); chk("R4 clear by one", v, 32'h0);

    // R8 set beats clear in the same cycle (source 0, rising edge)
    wr(4'h5, 32'h8000_0000);
    @(negedge clk); irq_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h8000_0000;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'h0, v); chk("R8 set wins over clear", v, 32'h8000_0000);
    wr(4'h0, 32'h8000_0000);
    rd(4'h0, v); chk("R5 edge cleared while line high", v, 32'h0);
    irq_in[0] = 1'b0; idle(4);

    // R6 / R10 / R9 read-only and unused offsets
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'h7, 32'h1234_5678);
    rd(4'h0, v); chk("R6 masked write ignored", v, 32'h0);
    rd(4'h2, v); chk("R6 enable untouched", v, 32'h0);
    rd(4'h7, v); chk("R10 vector write ignored", v, 32'hFFFF_FFFF);
    wr(4'h8, 32'hA5A5_0F0F);
    rd(4'h8, v); chk("R9 vector config storage", v, 32'hA5A5_0F0F);
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, v); chk("R9 offset 1 reads zero", v, 32'h0);
    rd(4'h9, v); chk("R9 offset 9 reads zero", v, 32'h0);
    rd(4'hF, v); chk("R9 offset 15 reads zero", v, 32'h0);

    // random trials
    for (int it = 0; it < 40; it++) begin
      logic [31:0] p, t, e, c, a;
      p = $urandom; t = $urandom; e = $urandom; c = $urandom;
      a = $urandom & $urandom;
      if (it % 5 == 0) a = 32'h0;
      if (it % 7 == 1) e = 32'hFFFF_FFFF;
      wr(4'h4, p); wr(4'h5, t); wr(4'h2, e); wr(4'h3, c);
      irq_in = rev32(~p); idle(4);
      wr(4'h0, 32'hFFFF_FFFF); idle(1);
      check_state(32'h0, e, c, "idle");
      irq_in = rev32(~p ^ a); idle(4);
      check_state(a, e, c, "R3 active");
      irq_in = rev32(~p); idle(4);
      check_state(a, e, c, "R5 latched");
      wr(4'h0, 32'hFFFF_FFFF); idle(1);
      check_state(32'h0, e, c, "cleared");
      irq_in = rev32(~p ^ a); idle(4);
      wr(4'h0, 32'hFFFF_FFFF); idle(1);
      check_state(a & ~t, e, c, "R5 clear while active");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule